// File: doc/BRIEF.md
# Nine-bit asynchronous serial transmitter

This block turns one byte plus a ninth bit into an eleven-bit serial frame on a single output line. The frame is a low start bit, then the eight data bits with the least significant bit first, then the ninth bit, then a high stop bit. The ninth bit is a free per-frame value, such as a parity bit or an address marker for a multidrop link. Between frames the line rests high.

Bit timing comes from a free-running oversampling counter that wraps every sixteen oversample ticks. A bit edge happens only when that counter wraps. An accepted write does not start the line at once: the start bit appears at the first wrap after the write. The oversample tick has two sources. The first is a prescaler on the block clock that gives a bit rate of one thirty-second or one sixty-fourth of the clock. The second is an external tick input that another timer provides.

The end of the frame is found from the contents of the shift register, without a bit counter. The first shift puts a one into the top of the register and every later shift fills with zero. When only that marker and the ninth bit remain at the bottom, one last shift finishes the frame and raises the done flag. Bytes enter through a valid/ready handshake. A byte is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low from that cycle until the done flag rises. A producer that sees `in_ready` low must hold its byte and wait. Offering a byte while `in_ready` is low does nothing.

Top module: `uart9_tx`

## Requirements
- R1: After reset, `txd` is 1, `ti` is 0 and `in_ready` is 1.
- R2: An accepted frame puts these bits on `txd`, one per bit period: 0, then `in_data[0]` through `in_data[7]`, then `in_bit9`, then 1.
- R3: The start bit appears on the first counter wrap after the accepting cycle, which is 16 oversample ticks after the previous wrap and not 16 ticks after the write. `txd` changes only on a wrap and holds its value for the 16 oversample ticks between wraps.
- R4: `ti` rises on the 11th wrap after the write, on the same clock edge at which the line returns to 1 for the stop bit.
- R5: `in_ready` falls in the cycle after the accepting cycle and stays low until `ti` rises. A byte offered while `in_ready` is low changes neither the frame in progress nor any later frame.
- R6: `ti` stays at 1 until `ti_clr` is high at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R7: When `use_fixed` is 1, one bit lasts 32 clocks with `fixed_slow` at 0 and 64 clocks with `fixed_slow` at 1. When `use_fixed` is 0, each high clock sample of `ext_tick` is one oversample tick, so one bit lasts 16 samples.
- R8: The ninth bit is sent exactly as given, both 0 and 1. A data pattern that looks like the end marker before the first shift, such as byte 0x02 with ninth bit 0, still gives a full frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| use_fixed | input | 1 | 1: prescaler sets the rate; 0: `ext_tick` sets it |
| fixed_slow | input | 1 | With the prescaler: 0 gives clk/32 per bit, 1 gives clk/64 |
| ext_tick | input | 1 | External oversample tick, one per high clock sample |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | A byte can be taken |
| in_data | input | DATA_W | Byte to send, least significant bit first |
| in_bit9 | input | 1 | Ninth bit of the frame |
| txd | output | 1 | Serial line, high when idle |
| ti | output | 1 | Transmit done flag, sticky |
| ti_clr | input | 1 | Clears `ti` |

## Verification
The bench builds the block with its defaults: 8 data bits, 16 oversample ticks per bit, and prescaler divides of 2 and 4. Most tests run on the external tick. Because the bench then knows where every counter wrap falls, it can check each bit both in the middle of its period and right after the wrap. It can also place a write partway through a period to show that the start aligns to the next wrap. The same control lets it put a clear pulse on exactly the edge where the done flag is set. Both prescaler settings are measured as the clock count from the start edge to the done flag.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  // Phase of the transmit control
  typedef enum logic [1:0] {
    PH_IDLE,   // line high, byte can be taken
    PH_WAIT,   // byte held, waiting for the next counter wrap
    PH_START,  // start bit on the line
    PH_DATA    // shift register bit 0 on the line
  } tx_phase_e;
endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_fixed,
  input  logic fixed_slow,
  input  logic ext_tick,
  output logic tick16
);
  localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW   = (MAXD > 1) ? $clog2(MAXD) : 1;
  localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);
  localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);

  logic [PW-1:0] pre;
  logic [PW-1:0] lim;
  logic          fix_tick;

  assign lim      = fixed_slow ? SLOW_LIM : FAST_LIM;
  assign fix_tick = use_fixed && (pre >= lim);
  assign tick16   = use_fixed ? fix_tick : ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre <= '0;
    else if (!use_fixed)    pre <= '0;
    else if (pre >= lim)    pre <= '0;
    else                    pre <= pre + PW'(1);
  end

  // R7: with the prescaler, no two oversample ticks come back to back
  a_r7_fixed_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (use_fixed && tick16) |=> (!use_fixed || !tick16));
endmodule

// File: rtl/uart9_div16.sv
module uart9_div16 #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  output logic roll
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt;

  assign roll = tick16 && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (roll)   cnt <= '0;
    else if (tick16) cnt <= cnt + CW'(1);
  end

  // R3: wraps are never on adjacent clock edges
  a_r3_roll_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> !roll);
endmodule

// File: rtl/uart9_shifter.sv
module uart9_shifter
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              roll,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_bit9,
  input  logic              ti_clr,
  output logic              txd,
  output logic              ti
);
  localparam int SR_W = DATA_W + 1;

  tx_phase_e       ph;
  logic [SR_W-1:0] sr;
  logic            armed;    // first shift done, the marker bit is inside
  logic            accept;
  logic            end_pat;

  assign in_ready = (ph == PH_IDLE);
  assign accept   = in_valid && in_ready;
  // marker at position 1, ninth bit at position 0, all above zero
  assign end_pat  = armed && (sr[SR_W-1:2] == '0) && sr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      sr    <= '0;
      armed <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (accept) begin
          sr    <= {in_bit9, in_data};
          armed <= 1'b0;
          ph    <= PH_WAIT;
        end
        PH_WAIT:  if (roll) ph <= PH_START;
        PH_START: if (roll) ph <= PH_DATA;
        PH_DATA: if (roll) begin
          sr    <= {~armed, sr[SR_W-1:1]};
          armed <= 1'b1;
          if (end_pat) ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ti <= 1'b0;
    else if ((ph == PH_DATA) && roll && end_pat) ti <= 1'b1;
    else if (ti_clr)                           ti <= 1'b0;
  end

  always_comb begin
    case (ph)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = sr[0];
      default:  txd = 1'b1;
    endcase
  end

  // R5: a taken byte closes the handshake on the next cycle
  a_r5_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R4: done flag rises together with the line going high again
  a_r4_ti_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> (txd && in_ready));
  // R6: flag holds without a clear
  a_r6_ti_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ti_clr) |=> ti);
  // R2: leaving the wait phase puts a low start bit on the line
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_WAIT) && roll) |=> !txd);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_fixed,
  input  logic              fixed_slow,
  input  logic              ext_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_bit9,
  output logic              txd,
  output logic              ti,
  input  logic              ti_clr
);
  logic tick16;
  logic roll;

  uart9_baud #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .use_fixed(use_fixed), .fixed_slow(fixed_slow),
    .ext_tick(ext_tick), .tick16(tick16)
  );

  uart9_div16 #(.OVS(OVS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .roll(roll)
  );

  uart9_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .roll(roll),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_bit9(in_bit9), .ti_clr(ti_clr), .txd(txd), .ti(ti)
  );

  // R3: the line moves only on a counter wrap
  a_r3_txd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !roll |=> $stable(txd));
endmodule

// File: tb/sim_uart9_tx.sv
module sim_uart9_tx;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       use_fixed = 1'b0;
  logic       fixed_slow = 1'b0;
  logic       ext_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_bit9 = 1'b0;
  logic       txd;
  logic       ti;
  logic       ti_clr = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  uart9_tx u0 (
    .clk(clk), .rst_n(rst_n), .use_fixed(use_fixed), .fixed_slow(fixed_slow),
    .ext_tick(ext_tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bit9(in_bit9), .txd(txd), .ti(ti), .ti_clr(ti_clr)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog act=%0d exp=<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_tick = 1'b1;
      @(negedge clk) ext_tick = 1'b0;
    end
  endtask

  task automatic do_write(input logic [7:0] d, input logic b9);
    @(negedge clk);
    chk(in_ready == 1'b1, "R5 ready before write", in_ready, 1);
    in_valid = 1'b1; in_data = d; in_bit9 = b9;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clear_ti();
    @(negedge clk) ti_clr = 1'b1;
    @(negedge clk) ti_clr = 1'b0;
    chk(ti == 1'b0, "R6 clear", ti, 0);
  endtask

  function automatic logic expv(input int g, input logic [7:0] d, input logic b9);
    if (g == 0)       return 1'b1;
    else if (g == 1)  return 1'b0;
    else if (g <= 9)  return d[g-2];
    else if (g == 10) return b9;
    else              return 1'b1;
  endfunction

  // One frame on the external tick, write placed on a wrap boundary
  task automatic run_frame(input logic [7:0] d, input logic b9,
                           input bit intrude, input bit clr_end);
    do_write(d, b9);
    for (int g = 1; g <= 11; g++) begin
      ticks(8);
      chk(txd == expv(g-1, d, b9), $sformatf("R3 mid bit %0d", g), txd, expv(g-1, d, b9));
      if (intrude && g == 4) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = ~d; in_bit9 = ~b9;
        ticks(8);
        chk(in_ready == 1'b0, "R5 ready low in frame", in_ready, 0);
        in_valid = 1'b0;
      end else if (clr_end && g == 11) begin
        ticks(7);
        @(negedge clk) begin ext_tick = 1'b1; ti_clr = 1'b1; end
        @(negedge clk) begin ext_tick = 1'b0; ti_clr = 1'b0; end
        chk(ti == 1'b1, "R6 set wins over clear", ti, 1);
      end else begin
        ticks(8);
      end
      chk(txd == expv(g, d, b9), $sformatf("R2 bit %0d", g), txd, expv(g, d, b9));
      if (g < 11) begin
        chk(ti == 1'b0, $sformatf("R4 ti early at %0d", g), ti, 0);
        chk(in_ready == 1'b0, "R5 ready low", in_ready, 0);
      end else begin
        chk(ti == 1'b1, "R4 ti on wrap 11", ti, 1);
        chk(in_ready == 1'b1, "R5 ready after ti", in_ready, 1);
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(ti == 1'b0, "R1 ti clear", ti, 0);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
  endtask

  task automatic t_frames();
    run_frame(8'hA5, 1'b1, 1'b0, 1'b0);   // R8 ninth bit 1
    ticks(32);
    chk(ti == 1'b1, "R6 ti held while idle", ti, 1);
    clear_ti();
    run_frame(8'h3C, 1'b0, 1'b0, 1'b0);   // R8 ninth bit 0
    clear_ti();
    run_frame(8'h02, 1'b0, 1'b0, 1'b0);   // R8 marker-like pattern
    clear_ti();
  endtask

  task automatic t_ignored_write();
    run_frame(8'h5A, 1'b0, 1'b1, 1'b0);   // R5 intruder during frame
    clear_ti();
    run_frame(8'hC3, 1'b1, 1'b0, 1'b0);   // R5 next frame unaffected
    clear_ti();
  endtask

  task automatic t_set_wins();
    run_frame(8'h81, 1'b1, 1'b0, 1'b1);   // R6
    clear_ti();
  endtask

  task automatic t_align();
    ticks(5);
    do_write(8'hFF, 1'b1);
    ticks(10);
    chk(txd == 1'b1, "R3 no start before wrap", txd, 1);
    ticks(1);
    chk(txd == 1'b0, "R3 start on next wrap", txd, 0);
    ticks(16 * 9);
    chk(ti == 1'b0, "R4 ti not on wrap 10", ti, 0);
    ticks(16);
    chk(ti == 1'b1, "R4 ti on wrap 11 aligned", ti, 1);
    clear_ti();
  endtask

  task automatic t_fixed(input logic slow, input int exp_cyc);
    int fall = -1;
    int ti_at = -1;
    int n = 0;
    use_fixed = 1'b1; fixed_slow = slow;
    do_reset();
    do_write(8'h96, 1'b0);
    while (ti_at < 0 && n < 3000) begin
      @(negedge clk);
      n++;
      if (fall < 0 && txd == 1'b0) fall = n;
      if (ti_at < 0 && ti == 1'b1) ti_at = n;
    end
    chk((fall > 0) && (ti_at - fall == exp_cyc),
        slow ? "R7 slow rate" : "R7 fast rate", ti_at - fall, exp_cyc);
    use_fixed = 1'b0; fixed_slow = 1'b0;
    do_reset();
  endtask

  initial begin
    t_reset();
    t_frames();
    t_ignored_write();
    t_set_wins();
    t_align();
    t_fixed(1'b0, 320);
    t_fixed(1'b1, 640);
    summary();
    $finish;
  end
endmodule